// File: doc/BRIEF.md
# Descriptor Ring Prefetch and Writeback Cache

This block fronts a circular ring of 16-byte descriptors that software keeps in host memory. Software describes the ring with a base address, a length in bytes and a starting head index, and publishes new work by moving a tail index. The block keeps a small local cache of descriptors. It prefetches new entries between its own fetch pointer and the tail using burst DMA reads. It hands them one at a time to a packet engine. It returns consumed entries to memory, starting at the head, using burst DMA writes, and then advances the head.

Both burst kinds stop at the end of the ring, so a burst never wraps inside itself. At most one read and one write are in flight at any time, and each is held on a request/done handshake toward a DMA engine. A writeback can be rounded down to an alignment mask. An interrupt-delay timer can force a writeback that ignores alignment. Cache entries become free again only when their write completes. For a transmit ring, each completed writeback raises a written-back interrupt cause. An idle output tells a drain controller that no transfer is pending.

Top module: `desc_ring_cache`

## Requirements
- R1: The ring length in descriptors is the configured byte length shifted right by 4. Read and write addresses are base plus index times 16.
- R2: The fetch count is tail minus fetch pointer when tail is at or ahead of the pointer. Otherwise it is ring length minus fetch pointer, so a read burst never crosses the ring end.
- R3: The fetch count is further limited to the free cache slots, which is capacity minus used minus unused entries.
- R4: A read request starts only when no read is outstanding and the count is nonzero. It keeps its address and count until `rd_done`.
- R5: On read completion the fetch pointer advances by the count and wraps to 0 exactly when it reaches the ring length. The fetched entries become available to the consumer.
- R6: The writeback count is the number of used entries. If head plus that count reaches the ring length, the count is clipped to ring length minus head. The remainder is then written back from index 0 by an automatic follow-up request that uses the same mask.
- R7: For an unclipped writeback with a nonzero mask, the count has the mask bits cleared. A resulting zero count, or a writeback already outstanding, issues nothing.
- R8: Used entries stay counted against the cache until the write completes. The head then advances by the count and wraps by subtracting the ring length.
- R9: A configuration write while used entries exist or a transfer is outstanding is rejected. It pulses `cfg_err` the next cycle and changes nothing. An accepted write loads base, length and head, empties the cache and sets the fetch pointer to 0.
- R10: With IS_TX set, every writeback completion pulses `irq_wb` for one cycle after the completing edge.
- R11: `force_wb` requests a writeback with a zero alignment mask.
- R12: `idle` is high exactly when no read, no write and no follow-up writeback is pending.
- R13: `cons_avail` is high while unused entries exist. Each cycle `cons_take` is high with an entry available, one entry moves from unused to used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_len_bytes | input | IDX_W+4 | Ring length in bytes |
| cfg_head | input | IDX_W | Initial head index |
| sw_tail | input | IDX_W | Software tail index |
| cfg_err | output | 1 | Rejected configuration write |
| head_idx | output | IDX_W | Current head index |
| rd_req | output | 1 | Read burst pending |
| rd_addr | output | ADDR_W | Read burst address |
| rd_count | output | CNT_W | Read burst length in descriptors |
| rd_done | input | 1 | Read burst complete |
| wr_req | output | 1 | Write burst pending |
| wr_addr | output | ADDR_W | Write burst address |
| wr_count | output | CNT_W | Write burst length in descriptors |
| wr_done | input | 1 | Write burst complete |
| cons_avail | output | 1 | An unused descriptor is available |
| cons_take | input | 1 | Consume one descriptor |
| wb_req | input | 1 | Writeback request from packet engine |
| wb_mask | input | CNT_W | Alignment mask for `wb_req` |
| force_wb | input | 1 | Timer-forced writeback |
| irq_wb | output | 1 | Written-back interrupt cause |
| idle | output | 1 | No transfer pending |

## Verification
The bench builds the block with IDX_W of 6, a cache depth of 8 and IS_TX set, on a 16-entry ring. The small cache lets a single fetch fill it, so the free-slot limit, the hold-off until writeback completion and the alignment round-down to zero are all reached within a few dozen cycles. The short ring lets one pass of the pointers reach the split fetch at the ring end, the wrap of the fetch pointer to 0, and a clipped writeback followed by its automatic remainder. A second configuration then moves to an 8-entry ring at a new base, both while busy and while idle.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
    // log2 of the descriptor size in bytes (16-byte descriptors)
    localparam int unsigned DESC_LOG2 = 4;
endpackage

// File: rtl/desc_fetch_plan.sv
// Sizes the next prefetch burst: stops at the tail or the ring end,
// whichever comes first, and never exceeds the free cache slots.
module desc_fetch_plan #(
    parameter int unsigned IDX_W = 12,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [IDX_W-1:0] ring_len,
    input  logic [IDX_W-1:0] fptr,
    input  logic [IDX_W-1:0] tail,
    input  logic [CNT_W-1:0] used_n,
    input  logic [CNT_W-1:0] unused_n,
    output logic [CNT_W-1:0] count
);
    localparam int unsigned EW = IDX_W + CNT_W;

    logic [IDX_W-1:0] span;
    logic [CNT_W-1:0] free_n;

    always_comb begin
        if (tail >= fptr) span = tail - fptr;
        else              span = ring_len - fptr;
        free_n = CNT_W'(DEPTH) - used_n - unused_n;
        if (EW'(span) < EW'(free_n)) count = CNT_W'(span);
        else                         count = free_n;
    end
endmodule

// File: rtl/desc_wb_plan.sv
// Sizes the next writeback burst: clipped at the ring end (with a
// remainder flag), otherwise rounded down by the alignment mask.
module desc_wb_plan #(
    parameter int unsigned IDX_W = 12,
    parameter int unsigned CNT_W = 5
) (
    input  logic [IDX_W-1:0] ring_len,
    input  logic [IDX_W-1:0] head,
    input  logic [CNT_W-1:0] used_n,
    input  logic [CNT_W-1:0] mask,
    output logic [CNT_W-1:0] count,
    output logic             more
);
    localparam int unsigned EW = IDX_W + CNT_W + 1;

    logic [EW-1:0]    reach;
    logic [IDX_W-1:0] to_end;

    always_comb begin
        reach  = EW'(head) + EW'(used_n);
        to_end = ring_len - head;
        if (reach >= EW'(ring_len)) begin
            count = CNT_W'(to_end);
            more  = 1'b1;
        end else begin
            count = used_n & ~mask;
            more  = 1'b0;
        end
    end
endmodule

// File: rtl/desc_ring_cache.sv
module desc_ring_cache
    import desc_ring_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 12,
    parameter int unsigned DEPTH  = 16,
    parameter bit          IS_TX  = 1'b1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned LEN_W = IDX_W + DESC_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len_bytes,
    input  logic [IDX_W-1:0]  cfg_head,
    input  logic [IDX_W-1:0]  sw_tail,
    output logic              cfg_err,
    output logic [IDX_W-1:0]  head_idx,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_count,
    input  logic              rd_done,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CNT_W-1:0]  wr_count,
    input  logic              wr_done,
    output logic              cons_avail,
    input  logic              cons_take,
    input  logic              wb_req,
    input  logic [CNT_W-1:0]  wb_mask,
    input  logic              force_wb,
    output logic              irq_wb,
    output logic              idle
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  len;
        logic [IDX_W-1:0]  head;
        logic [IDX_W-1:0]  fptr;
        logic [CNT_W-1:0]  used_n;
        logic [CNT_W-1:0]  unused_n;
        logic [CNT_W-1:0]  rd_n;
        logic [CNT_W-1:0]  wr_n;
        logic [CNT_W-1:0]  mask;
        logic              more;
        logic              retry;
        logic              err;
        logic              irq;
    } state_t;

    state_t s_q, s_d;

    logic [CNT_W-1:0] fetch_cnt;
    logic [CNT_W-1:0] wb_cnt;
    logic             wb_more;
    logic [CNT_W-1:0] wb_sel_mask;

    // internal views for the bound checker
    logic [IDX_W-1:0] ring_len_q;
    logic [IDX_W-1:0] fetch_ptr_q;
    logic [CNT_W-1:0] used_q;
    logic [CNT_W-1:0] unused_q;
    assign ring_len_q  = s_q.len;
    assign fetch_ptr_q = s_q.fptr;
    assign used_q      = s_q.used_n;
    assign unused_q    = s_q.unused_n;

    desc_fetch_plan #(.IDX_W(IDX_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fetch (
        .ring_len (s_q.len),
        .fptr     (s_q.fptr),
        .tail     (sw_tail),
        .used_n   (s_q.used_n),
        .unused_n (s_q.unused_n),
        .count    (fetch_cnt)
    );

    // follow-up writebacks reuse the stored mask; timer writebacks use none
    always_comb begin
        if (s_q.retry)   wb_sel_mask = s_q.mask;
        else if (force_wb) wb_sel_mask = '0;
        else             wb_sel_mask = wb_mask;
    end

    desc_wb_plan #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_wb (
        .ring_len (s_q.len),
        .head     (s_q.head),
        .used_n   (s_q.used_n),
        .mask     (wb_sel_mask),
        .count    (wb_cnt),
        .more     (wb_more)
    );

    logic             busy;
    logic             take_ok;
    logic             rd_fin;
    logic             wr_fin;
    logic [IDX_W:0]   fsum;
    logic [IDX_W:0]   hsum;
    logic [CNT_W-1:0] add_n;
    logic [CNT_W-1:0] rel_n;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        s_d.irq = 1'b0;

        busy    = (s_q.used_n != '0) || (s_q.rd_n != '0) ||
                  (s_q.wr_n != '0) || s_q.retry;
        take_ok = cons_take && (s_q.unused_n != '0);
        rd_fin  = rd_done && (s_q.rd_n != '0);
        wr_fin  = wr_done && (s_q.wr_n != '0);
        fsum    = (IDX_W+1)'(s_q.fptr) + (IDX_W+1)'(s_q.rd_n);
        hsum    = (IDX_W+1)'(s_q.head) + (IDX_W+1)'(s_q.wr_n);
        add_n   = rd_fin ? s_q.rd_n : '0;
        rel_n   = wr_fin ? s_q.wr_n : '0;

        if (cfg_wr) begin
            if (busy) begin
                s_d.err = 1'b1;
            end else begin
                s_d.base     = cfg_base;
                s_d.len      = IDX_W'(cfg_len_bytes >> DESC_LOG2);
                s_d.head     = cfg_head;
                s_d.fptr     = '0;
                s_d.used_n   = '0;
                s_d.unused_n = '0;
                s_d.more     = 1'b0;
                s_d.retry    = 1'b0;
            end
        end else begin
            // prefetch side
            if (rd_fin) begin
                if (fsum == (IDX_W+1)'(s_q.len)) s_d.fptr = '0;
                else                             s_d.fptr = IDX_W'(fsum);
                s_d.rd_n = '0;
            end else if (s_q.rd_n == '0 && s_q.len != '0 && fetch_cnt != '0) begin
                s_d.rd_n = fetch_cnt;
            end

            // cache occupancy
            s_d.unused_n = s_q.unused_n + add_n - (take_ok ? CNT_W'(1) : '0);
            s_d.used_n   = s_q.used_n - rel_n + (take_ok ? CNT_W'(1) : '0);

            // writeback side
            if (wr_fin) begin
                if (hsum >= (IDX_W+1)'(s_q.len))
                    s_d.head = IDX_W'(hsum - (IDX_W+1)'(s_q.len));
                else
                    s_d.head = IDX_W'(hsum);
                s_d.wr_n  = '0;
                s_d.irq   = IS_TX;
                s_d.retry = s_q.more;
                s_d.more  = 1'b0;
            end else if (s_q.wr_n == '0 && (s_q.retry || wb_req || force_wb)) begin
                s_d.retry = 1'b0;
                s_d.mask  = wb_sel_mask;
                if (wb_cnt != '0) begin
                    s_d.wr_n = wb_cnt;
                    s_d.more = wb_more;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_err    = s_q.err;
    assign head_idx   = s_q.head;
    assign rd_req     = (s_q.rd_n != '0);
    assign rd_addr    = s_q.base + (ADDR_W'(s_q.fptr) << DESC_LOG2);
    assign rd_count   = s_q.rd_n;
    assign wr_req     = (s_q.wr_n != '0);
    assign wr_addr    = s_q.base + (ADDR_W'(s_q.head) << DESC_LOG2);
    assign wr_count   = s_q.wr_n;
    assign cons_avail = (s_q.unused_n != '0);
    assign irq_wb     = s_q.irq;
    assign idle       = (s_q.rd_n == '0) && (s_q.wr_n == '0) && !s_q.retry;
endmodule

// File: rtl/desc_ring_cache_chk.sv
module desc_ring_cache_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 12,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              cfg_err,
    input logic [IDX_W-1:0]  head_idx,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CNT_W-1:0]  rd_count,
    input logic              rd_done,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_count,
    input logic              wr_done,
    input logic              irq_wb,
    input logic              idle,
    input logic [IDX_W-1:0]  ring_len_q,
    input logic [IDX_W-1:0]  fetch_ptr_q,
    input logic [CNT_W-1:0]  used_q,
    input logic [CNT_W-1:0]  unused_q
);
    assert_fetch_no_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ((IDX_W+1)'(fetch_ptr_q) + (IDX_W+1)'(rd_count) <= (IDX_W+1)'(ring_len_q)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((CNT_W+1)'(used_q) + (CNT_W+1)'(unused_q) <= (CNT_W+1)'(DEPTH)));

    assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_done) |=> (rd_req && $stable(rd_addr) && $stable(rd_count)));

    assert_fetch_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_count != '0));

    assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_count)));

    assert_head_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_len_q != '0) |-> (head_idx < ring_len_q));

    assert_cfg_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (rd_req || wr_req)) |=> cfg_err);

    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wb |-> $past(wr_req && wr_done));

    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!rd_req && !wr_req));
endmodule

bind desc_ring_cache desc_ring_cache_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_err     (cfg_err),
    .head_idx    (head_idx),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .rd_count    (rd_count),
    .rd_done     (rd_done),
    .wr_req      (wr_req),
    .wr_addr     (wr_addr),
    .wr_count    (wr_count),
    .wr_done     (wr_done),
    .irq_wb      (irq_wb),
    .idle        (idle),
    .ring_len_q  (ring_len_q),
    .fetch_ptr_q (fetch_ptr_q),
    .used_q      (used_q),
    .unused_q    (unused_q)
);

// File: tb/desc_ring_cache_test.sv
`timescale 1ns/1ps
module desc_ring_cache_test;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned IDX_W  = 6;
    localparam int unsigned DEPTH  = 8;
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
    localparam int unsigned LEN_W  = IDX_W + 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [LEN_W-1:0]  cfg_len_bytes = '0;
    logic [IDX_W-1:0]  cfg_head = '0;
    logic [IDX_W-1:0]  sw_tail = '0;
    logic              cfg_err;
    logic [IDX_W-1:0]  head_idx;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [CNT_W-1:0]  rd_count;
    logic              rd_done = 1'b0;
    logic              wr_req;
    logic [ADDR_W-1:0] wr_addr;
    logic [CNT_W-1:0]  wr_count;
    logic              wr_done = 1'b0;
    logic              cons_avail;
    logic              cons_take = 1'b0;
    logic              wb_req = 1'b0;
    logic [CNT_W-1:0]  wb_mask = '0;
    logic              force_wb = 1'b0;
    logic              irq_wb;
    logic              idle;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    desc_ring_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .IS_TX(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_base(cfg_base),
        .cfg_len_bytes(cfg_len_bytes), .cfg_head(cfg_head), .sw_tail(sw_tail),
        .cfg_err(cfg_err), .head_idx(head_idx), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_count(rd_count), .rd_done(rd_done), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_count(wr_count), .wr_done(wr_done), .cons_avail(cons_avail),
        .cons_take(cons_take), .wb_req(wb_req), .wb_mask(wb_mask), .force_wb(force_wb),
        .irq_wb(irq_wb), .idle(idle)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, string what, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic longint at(longint base, int idx);
        return base + longint'(idx) * 16;
    endfunction

    task automatic pulse_rd_done();
        rd_done = 1'b1; tick(); rd_done = 1'b0;
    endtask

    task automatic pulse_wr_done();
        wr_done = 1'b1; tick(); wr_done = 1'b0;
    endtask

    task automatic take(int n);
        cons_take = 1'b1;
        repeat (n) tick();
        cons_take = 1'b0;
    endtask

    task automatic cfg(longint base, int bytes, int head);
        cfg_base = ADDR_W'(base); cfg_len_bytes = LEN_W'(bytes); cfg_head = IDX_W'(head);
        cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R12", "idle after reset", idle, 1);
        check("R4", "rd_req after reset", rd_req, 0);
        check("R13", "cons_avail after reset", cons_avail, 0);
        check("R9", "head after reset", head_idx, 0);
    endtask

    task automatic t_first_fetch();
        sw_tail = 0;
        cfg(32'h1000, 256, 0);
        tick();
        check("R2", "no fetch when tail equals pointer", rd_req, 0);
        sw_tail = 5;
        tick();
        check("R2", "fetch count tail-ptr", rd_count, 5);
        check("R1", "fetch address", rd_addr, at(32'h1000, 0));
        check("R12", "idle low while reading", idle, 0);
        tick(); tick();
        check("R4", "count held while outstanding", rd_count, 5);
        pulse_rd_done();
        check("R13", "entries available after fetch", cons_avail, 1);
        tick();
        check("R4", "no fetch of zero count", rd_req, 0);
    endtask

    task automatic t_free_limit();
        sw_tail = 14;
        tick();
        check("R3", "fetch limited by free slots", rd_count, 3);
        check("R1", "second fetch address", rd_addr, at(32'h1000, 5));
        pulse_rd_done();
        tick();
        check("R3", "no fetch with full cache", rd_req, 0);
    endtask

    task automatic t_aligned_wb();
        take(6);
        wb_mask = 3; wb_req = 1'b1; tick(); wb_req = 1'b0;
        check("R7", "aligned writeback count", wr_count, 4);
        check("R8", "writeback address", wr_addr, at(32'h1000, 0));
        tick();
        check("R8", "slots not freed before write completes", rd_req, 0);
        pulse_wr_done();
        check("R8", "head advanced", head_idx, 4);
        check("R10", "irq after completion", irq_wb, 1);
        tick();
        check("R10", "irq single cycle", irq_wb, 0);
        check("R3", "refetch after release", rd_count, 4);
        check("R2", "refetch address", rd_addr, at(32'h1000, 8));
        wb_mask = 7; wb_req = 1'b1; tick(); wb_req = 1'b0;
        check("R7", "rounded to zero issues nothing", wr_req, 0);
        pulse_rd_done();
        tick();
        check("R3", "cache full again", rd_req, 0);
    endtask

    task automatic t_forced_wb();
        take(6);
        wb_mask = 7; force_wb = 1'b1; tick(); force_wb = 1'b0;
        check("R11", "forced writeback ignores mask", wr_count, 8);
        check("R11", "forced writeback address", wr_addr, at(32'h1000, 4));
        pulse_wr_done();
        check("R8", "head after forced writeback", head_idx, 12);
        tick();
        check("R2", "fetch to tail", rd_count, 2);
        pulse_rd_done();
    endtask

    task automatic t_ring_end_fetch();
        sw_tail = 3;
        tick();
        check("R2", "fetch stops at ring end", rd_count, 2);
        check("R1", "ring end address", rd_addr, at(32'h1000, 14));
        pulse_rd_done();
        tick();
        check("R5", "pointer wrapped to zero", rd_addr, at(32'h1000, 0));
        check("R5", "fetch after wrap", rd_count, 3);
        pulse_rd_done();
    endtask

    task automatic t_split_wb();
        take(7);
        force_wb = 1'b1; tick(); force_wb = 1'b0;
        check("R6", "writeback clipped at ring end", wr_count, 4);
        check("R6", "clipped writeback address", wr_addr, at(32'h1000, 12));
        pulse_wr_done();
        check("R8", "head wrapped", head_idx, 0);
        check("R12", "not idle while remainder pending", idle, 0);
        tick();
        check("R6", "remainder writeback count", wr_count, 3);
        check("R6", "remainder address", wr_addr, at(32'h1000, 0));
        pulse_wr_done();
        check("R8", "head after remainder", head_idx, 3);
        check("R12", "idle after drain", idle, 1);
    endtask

    task automatic t_cfg();
        sw_tail = 6;
        tick();
        check("R2", "fetch before reconfig", rd_count, 3);
        cfg(32'h2000, 512, 9);
        check("R9", "busy config rejected", cfg_err, 1);
        check("R9", "head unchanged", head_idx, 3);
        check("R9", "fetch unchanged", rd_count, 3);
        pulse_rd_done();
        check("R9", "err is one pulse", cfg_err, 0);
        tick();
        cfg(32'h2000, 128, 2);
        check("R9", "accepted config no err", cfg_err, 0);
        check("R9", "head loaded", head_idx, 2);
        check("R13", "cache emptied", cons_avail, 0);
        tick();
        check("R9", "fetch from index zero", rd_addr, at(32'h2000, 0));
        check("R1", "new ring count", rd_count, 6);
        pulse_rd_done();
        take(1);
        check("R13", "take leaves entries", cons_avail, 1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_first_fetch();
        t_free_limit();
        t_aligned_wb();
        t_forced_wb();
        t_ring_end_fetch();
        t_split_wb();
        t_cfg();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule